// File: doc/BRIEF.md
# Cache-Line-Aware Write Burst Segmenter

This block sits on the request path of a DMA engine in front of a bus master. It accepts one transfer request at a time: a direction, a 64-bit byte start address and a length in dwords. It cuts the request into bus bursts and emits one descriptor per burst. Each descriptor carries a four-bit bus command, the burst address, the burst length in dwords and a flag that requests a dual address cycle.

For writes in conventional (PCI) mode, the command choice follows the programmed cache line size. The block sends ordinary memory writes until the running address lands on a line boundary. From there it sends write-and-invalidate bursts made of whole lines. Any short tail goes out as an ordinary write. In PCI-X mode, or when the line size is unusable, every write is an ordinary write. Reads take a line-read command or a plain read, depending on the mode and on how the burst fits the line. A configurable cap limits every burst.

Top module: `cl_burst_segmenter`

## Requirements
- R1: After reset no descriptor is offered (`bst_valid` low) and `req_ready` is high.
- R2: A request is taken on a cycle where `req_valid` and `req_ready` are both high. The configuration inputs (line size, mode, cap) are captured in that cycle, and later changes do not affect that request. An offered descriptor holds all its fields steady while `bst_ready` is low.
- R3: Bursts of one request are contiguous: each burst starts at the byte address where the previous one ended (previous address plus 4 × length), and the lengths add up to the request length. A request of zero dwords is accepted and produces no descriptor.
- R4: Every burst length is between 1 and the cap. A cap of 0 acts as a cap of 1 dword.
- R5: Write-and-invalidate is enabled when `cfg_pcix` is 0 and `cfg_line_dw` (line size in dwords) is a nonzero power of two. The line offset is the dword address (byte address bits 63:2) modulo the line size. With write-and-invalidate enabled and a nonzero offset, the burst uses command 0111 (memory write) with length min(remaining, cap, dwords left to the next boundary).
- R6: With write-and-invalidate enabled, offset zero, and min(remaining, cap) of at least one line, the burst uses command 1111 (write and invalidate). Its length is min(remaining, cap) rounded down to a whole number of lines. If the cap is below one line, command 0111 with the cap length is used instead.
- R7: With write-and-invalidate enabled, an aligned remainder shorter than one line goes out as command 0111 carrying the whole remainder.
- R8: In PCI-X mode, or when the line size is zero or not a power of two, every write burst uses command 0111 with length min(remaining, cap).
- R9: In PCI mode, a read burst has length min(remaining, cap). It uses command 1110 (memory read line) when the line size is valid, the offset is zero and the burst covers at least one line. Otherwise it uses 0110 (memory read).
- R10: In PCI-X mode every read burst uses command 1110 (memory read block), with length min(remaining, cap).
- R11: `bst_dac` is high exactly when bits 63:32 of that burst's address are nonzero. It is evaluated separately for each burst and works the same in both modes.
- R12: `req_ready` is also high in the cycle in which the last descriptor of a request is handed over, so the next request can be accepted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | 64 | Start byte address (dword aligned) |
| req_len_dw | input | 16 | Request length in dwords |
| cfg_line_dw | input | 8 | Cache line size in dwords |
| cfg_pcix | input | 1 | 1 = PCI-X mode, 0 = PCI mode |
| cfg_max_dw | input | 16 | Burst length cap in dwords |
| bst_valid | output | 1 | Descriptor offered |
| bst_ready | input | 1 | Descriptor taken |
| bst_cmd | output | 4 | Bus command code |
| bst_addr | output | 64 | Burst start byte address |
| bst_len_dw | output | 16 | Burst length in dwords |
| bst_dac | output | 1 | Dual address cycle needed |

## Verification
Two events can land in the same cycle: the handover of a request's final descriptor and the acceptance of the next request. The bench provokes this with `bst_ready` held high. While the last burst of a single-burst read is on the outputs, it raises a new write request. It then checks that `req_ready` is high in that cycle and that the new request's first descriptor appears on the very next cycle, with its own command and address. A second overlap exercises the same state update from two sides. There, the cap, the line boundary and the remaining length all bound one burst together, and the bench checks that the smallest of them wins.

// File: rtl/seg_pkg.sv
package seg_pkg;

    localparam int ADDR_W = 64;
    localparam int LEN_W  = 16;
    localparam int CLS_W  = 8;
    localparam int HI_LSB = 32;

    typedef enum logic [3:0] {
        CMD_MEM_RD  = 4'b0110,
        CMD_MEM_WR  = 4'b0111,
        CMD_LINE_RD = 4'b1110,
        CMD_WR_INV  = 4'b1111
    } bus_cmd_e;

    typedef struct packed {
        logic             pcix;
        logic             line_ok;
        logic [LEN_W-1:0] line_len;
        logic [LEN_W-1:0] line_mask;
        logic [LEN_W-1:0] cap;
    } seg_cfg_t;

    typedef struct packed {
        logic              busy;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  rem;
    } seg_state_t;

    typedef struct packed {
        bus_cmd_e          cmd;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic              dac;
    } burst_desc_t;

    function automatic logic is_pow2(input logic [CLS_W-1:0] v);
        return (v != '0) && ((v & (v - CLS_W'(1))) == '0);
    endfunction

    function automatic logic [LEN_W-1:0] min_len(input logic [LEN_W-1:0] a,
                                                  input logic [LEN_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/seg_cfg_decode.sv
module seg_cfg_decode
    import seg_pkg::*;
(
    input  logic [CLS_W-1:0] line_dw,
    input  logic             pcix,
    input  logic [LEN_W-1:0] max_dw,
    output seg_cfg_t         cfg
);
    logic             ok;
    logic [LEN_W-1:0] ext;

    always_comb begin
        ok            = is_pow2(line_dw);
        ext           = LEN_W'(line_dw);
        cfg.pcix      = pcix;
        cfg.line_ok   = ok;
        cfg.line_len  = ok ? ext : LEN_W'(1);
        cfg.line_mask = ok ? (ext - LEN_W'(1)) : '0;
        cfg.cap       = (max_dw == '0) ? LEN_W'(1) : max_dw;
    end
endmodule

// File: rtl/seg_burst_plan.sv
module seg_burst_plan
    import seg_pkg::*;
(
    input  seg_state_t  st,
    input  seg_cfg_t    cfg,
    output burst_desc_t desc,
    output logic        last
);
    logic [LEN_W-1:0] lim;
    logic [LEN_W-1:0] off;
    logic [LEN_W-1:0] room;
    logic             aligned;
    logic             wi_en;
    logic             full_line;

    always_comb begin
        lim       = min_len(st.rem, cfg.cap);
        off       = st.addr[2 +: LEN_W] & cfg.line_mask;
        room      = cfg.line_len - off;
        aligned   = (off == '0);
        wi_en     = st.write && !cfg.pcix && cfg.line_ok;
        full_line = (lim >= cfg.line_len);

        desc.addr = st.addr;
        desc.dac  = (st.addr[ADDR_W-1:HI_LSB] != '0);
        desc.len  = lim;
        desc.cmd  = CMD_MEM_WR;

        if (st.write) begin
            if (wi_en && !aligned) begin
                desc.len = min_len(lim, room);
                desc.cmd = CMD_MEM_WR;
            end else if (wi_en && full_line) begin
                desc.len = lim & ~cfg.line_mask;
                desc.cmd = CMD_WR_INV;
            end else begin
                desc.len = lim;
                desc.cmd = CMD_MEM_WR;
            end
        end else begin
            desc.len = lim;
            if (cfg.pcix) begin
                desc.cmd = CMD_LINE_RD;
            end else if (cfg.line_ok && aligned && full_line) begin
                desc.cmd = CMD_LINE_RD;
            end else begin
                desc.cmd = CMD_MEM_RD;
            end
        end

        last = (st.rem == desc.len);
    end
endmodule

// File: rtl/seg_tracker.sv
module seg_tracker
    import seg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len_dw,
    input  seg_cfg_t          cfg_in,
    input  logic              fire,
    input  logic              last,
    input  logic [LEN_W-1:0]  step_len,
    output seg_state_t        st_q,
    output seg_cfg_t          cfg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            cfg_q <= '0;
        end else if (accept) begin
            st_q.busy  <= (req_len_dw != '0);
            st_q.write <= req_write;
            st_q.addr  <= req_addr;
            st_q.rem   <= req_len_dw;
            cfg_q      <= cfg_in;
        end else if (fire) begin
            st_q.addr <= st_q.addr + ADDR_W'({step_len, 2'b00});
            st_q.rem  <= st_q.rem - step_len;
            if (last) begin
                st_q.busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cl_burst_segmenter.sv
module cl_burst_segmenter
    import seg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len_dw,
    input  logic [CLS_W-1:0]  cfg_line_dw,
    input  logic              cfg_pcix,
    input  logic [LEN_W-1:0]  cfg_max_dw,
    output logic              bst_valid,
    input  logic              bst_ready,
    output logic [3:0]        bst_cmd,
    output logic [ADDR_W-1:0] bst_addr,
    output logic [LEN_W-1:0]  bst_len_dw,
    output logic              bst_dac
);
    seg_cfg_t    cfg_dec;
    seg_cfg_t    cfg_q;
    seg_state_t  st_q;
    burst_desc_t desc;
    logic        last;
    logic        fire;
    logic        accept;

    seg_cfg_decode u_dec (
        .line_dw (cfg_line_dw),
        .pcix    (cfg_pcix),
        .max_dw  (cfg_max_dw),
        .cfg     (cfg_dec)
    );

    seg_burst_plan u_plan (
        .st   (st_q),
        .cfg  (cfg_q),
        .desc (desc),
        .last (last)
    );

    assign fire      = st_q.busy && bst_ready;
    assign req_ready = !st_q.busy || (fire && last);
    assign accept    = req_valid && req_ready;

    seg_tracker u_trk (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_len_dw (req_len_dw),
        .cfg_in     (cfg_dec),
        .fire       (fire),
        .last       (last),
        .step_len   (desc.len),
        .st_q       (st_q),
        .cfg_q      (cfg_q)
    );

    assign bst_valid  = st_q.busy;
    assign bst_cmd    = desc.cmd;
    assign bst_addr   = desc.addr;
    assign bst_len_dw = desc.len;
    assign bst_dac    = desc.dac;
endmodule

// File: rtl/cl_burst_segmenter_chk.sv
module cl_burst_segmenter_chk
    import seg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              bst_valid,
    input logic              bst_ready,
    input logic [3:0]        bst_cmd,
    input logic [ADDR_W-1:0] bst_addr,
    input logic [LEN_W-1:0]  bst_len_dw,
    input logic              pcix_q,
    input logic              line_ok_q,
    input logic [LEN_W-1:0]  mask_q,
    input logic [LEN_W-1:0]  cap_q
);
    p_hold_stable_r2: assert property (@(posedge clk) disable iff (rst)
        bst_valid && !bst_ready |=> bst_valid && $stable(bst_cmd)
            && $stable(bst_addr) && $stable(bst_len_dw));

    p_contig_r3: assert property (@(posedge clk) disable iff (rst)
        bst_valid && bst_ready && !req_ready |=> bst_valid
            && bst_addr == $past(bst_addr) + ADDR_W'({$past(bst_len_dw), 2'b00}));

    p_len_range_r4: assert property (@(posedge clk) disable iff (rst)
        bst_valid |-> (bst_len_dw != '0) && (bst_len_dw <= cap_q));

    p_whole_lines_r6: assert property (@(posedge clk) disable iff (rst)
        bst_valid && bst_cmd == 4'b1111 |->
            ((bst_len_dw & mask_q) == '0) && ((bst_addr[2 +: LEN_W] & mask_q) == '0));

    p_inv_mode_r8: assert property (@(posedge clk) disable iff (rst)
        bst_valid && bst_cmd == 4'b1111 |-> !pcix_q && line_ok_q);

    p_idle_ready_r12: assert property (@(posedge clk) disable iff (rst)
        !bst_valid |-> req_ready);
endmodule

bind cl_burst_segmenter cl_burst_segmenter_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .bst_valid  (bst_valid),
    .bst_ready  (bst_ready),
    .bst_cmd    (bst_cmd),
    .bst_addr   (bst_addr),
    .bst_len_dw (bst_len_dw),
    .pcix_q     (cfg_q.pcix),
    .line_ok_q  (cfg_q.line_ok),
    .mask_q     (cfg_q.line_mask),
    .cap_q      (cfg_q.cap)
);

// File: tb/cl_burst_segmenter_test.sv
module cl_burst_segmenter_test;
    localparam int CLK_P = 10;
    localparam logic [3:0] MR  = 4'b0110;
    localparam logic [3:0] MW  = 4'b0111;
    localparam logic [3:0] LRD = 4'b1110;
    localparam logic [3:0] WI  = 4'b1111;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [63:0] req_addr = '0;
    logic [15:0] req_len_dw = '0;
    logic [7:0]  cfg_line_dw = '0;
    logic        cfg_pcix = 1'b0;
    logic [15:0] cfg_max_dw = 16'd64;
    logic        bst_valid;
    logic        bst_ready = 1'b1;
    logic [3:0]  bst_cmd;
    logic [63:0] bst_addr;
    logic [15:0] bst_len_dw;
    logic        bst_dac;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    cl_burst_segmenter uut (.*);

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_burst(input string tag, input logic [3:0] cmd,
                               input logic [63:0] addr, input int len, input bit dac);
        checks++;
        if (!(bst_valid === 1'b1 && bst_cmd === cmd && bst_addr === addr
              && bst_len_dw === 16'(len) && bst_dac === dac)) begin
            errors++;
            $display("FAIL %s: got v=%b cmd=%b addr=%h len=%0d dac=%b, expected v=1 cmd=%b addr=%h len=%0d dac=%b",
                     tag, bst_valid, bst_cmd, bst_addr, bst_len_dw, bst_dac, cmd, addr, len, dac);
        end
    endtask

    task automatic expect_burst(input string tag, input logic [3:0] cmd,
                                input logic [63:0] addr, input int len, input bit dac);
        check_burst(tag, cmd, addr, len, dac);
        tick();
    endtask

    task automatic expect_idle(input string tag);
        checks++;
        if (!(bst_valid === 1'b0 && req_ready === 1'b1)) begin
            errors++;
            $display("FAIL %s: got valid=%b ready=%b, expected valid=0 ready=1",
                     tag, bst_valid, req_ready);
        end
    endtask

    task automatic drive_req(input bit wr, input logic [63:0] addr, input int len,
                             input int cls, input bit pcix, input int cap);
        req_write   = wr;
        req_addr    = addr;
        req_len_dw  = 16'(len);
        cfg_line_dw = 8'(cls);
        cfg_pcix    = pcix;
        cfg_max_dw  = 16'(cap);
        req_valid   = 1'b1;
    endtask

    task automatic start_req(input string tag, input bit wr, input logic [63:0] addr,
                             input int len, input int cls, input bit pcix, input int cap);
        expect_idle(tag);
        drive_req(wr, addr, len, cls, pcix, cap);
        tick();
        req_valid = 1'b0;
    endtask

    task automatic t_unaligned_write();
        start_req("R5 unaligned start", 1, 64'h100C, 30, 8, 0, 64);
        expect_burst("R5 head to boundary", MW, 64'h100C, 5, 0);
        expect_burst("R6 whole lines", WI, 64'h1020, 24, 0);
        expect_burst("R7 short tail", MW, 64'h1080, 1, 0);
        expect_idle("R3 request drained");
    endtask

    task automatic t_cap_rounding();
        start_req("R6 cap rounding", 1, 64'h2000, 40, 8, 0, 20);
        expect_burst("R6 cap 20 -> 16", WI, 64'h2000, 16, 0);
        expect_burst("R6 second rounded", WI, 64'h2040, 16, 0);
        expect_burst("R6 last full line", WI, 64'h2080, 8, 0);
        expect_idle("R3 after rounding");
        start_req("R6 cap below line", 1, 64'h3000, 10, 16, 0, 8);
        expect_burst("R6 cap below line uses MW", MW, 64'h3000, 8, 0);
        expect_burst("R5 cap/boundary/remaining minimum", MW, 64'h3020, 2, 0);
        expect_idle("R3 after cap below line");
    endtask

    task automatic t_bad_line();
        start_req("R8 line 12", 1, 64'h1004, 20, 12, 0, 64);
        expect_burst("R8 non power of two", MW, 64'h1004, 20, 0);
        start_req("R8 line 0", 1, 64'h4000, 70, 0, 0, 64);
        expect_burst("R8 zero line capped", MW, 64'h4000, 64, 0);
        expect_burst("R8 zero line rest", MW, 64'h4100, 6, 0);
        expect_idle("R3 after zero line");
    endtask

    task automatic t_pcix_write();
        start_req("R8 pcix write", 1, 64'h0000_0001_0000_5000, 16, 8, 1, 64);
        expect_burst("R8 pcix write is MW with R11 dac", MW, 64'h0000_0001_0000_5000, 16, 1);
    endtask

    task automatic t_reads();
        start_req("R9 pci read", 0, 64'h6000, 20, 8, 0, 16);
        expect_burst("R9 read line", LRD, 64'h6000, 16, 0);
        expect_burst("R9 short read", MR, 64'h6040, 4, 0);
        start_req("R9 unaligned read", 0, 64'h6004, 9, 8, 0, 64);
        expect_burst("R9 unaligned read no split", MR, 64'h6004, 9, 0);
        start_req("R10 pcix read", 0, 64'h7004, 5, 8, 1, 64);
        expect_burst("R10 read block", LRD, 64'h7004, 5, 0);
    endtask

    task automatic t_dac_cross();
        start_req("R11 crossing", 1, 64'hFFFF_FFF8, 6, 8, 1, 4);
        expect_burst("R11 below 4G", MW, 64'hFFFF_FFF8, 4, 0);
        expect_burst("R11 above 4G", MW, 64'h0000_0001_0000_0008, 2, 1);
    endtask

    task automatic t_cap_zero();
        start_req("R4 cap zero", 0, 64'h8000, 3, 8, 1, 0);
        for (int i = 0; i < 3; i++)
            expect_burst("R4 cap zero acts as one", LRD, 64'h8000 + 64'(4 * i), 1, 0);
        expect_idle("R4 done");
    endtask

    task automatic t_zero_len();
        start_req("R3 zero length", 1, 64'h9000, 0, 8, 0, 64);
        expect_idle("R3 zero length no descriptor");
        tick();
        expect_idle("R3 zero length still idle");
    endtask

    task automatic t_stall_cfg();
        start_req("R2 stall", 1, 64'h9000, 8, 4, 0, 64);
        cfg_pcix    = 1'b1;
        cfg_line_dw = 8'd0;
        cfg_max_dw  = 16'd1;
        bst_ready   = 1'b0;
        check_burst("R2 stalled", WI, 64'h9000, 8, 0);
        tick();
        check_burst("R2 held 1", WI, 64'h9000, 8, 0);
        tick();
        check_burst("R2 held 2 config captured", WI, 64'h9000, 8, 0);
        bst_ready = 1'b1;
        tick();
        expect_idle("R2 released");
    endtask

    task automatic t_back_to_back();
        start_req("R12 first", 0, 64'hA000, 8, 8, 0, 64);
        check_burst("R12 first is line read", LRD, 64'hA000, 8, 0);
        checks++;
        if (req_ready !== 1'b1) begin
            errors++;
            $display("FAIL R12: got req_ready=%b, expected 1 on last handover", req_ready);
        end
        drive_req(1, 64'hB000, 8, 8, 0, 64);
        tick();
        req_valid = 1'b0;
        expect_burst("R12 next request at once", WI, 64'hB000, 8, 0);
        expect_idle("R12 drained");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (!(bst_valid === 1'b0 && req_ready === 1'b1)) begin
            errors++;
            $display("FAIL R1: got valid=%b ready=%b, expected valid=0 ready=1",
                     bst_valid, req_ready);
        end
        rst = 1'b0;
        tick();
        expect_idle("R1 after reset");
        t_unaligned_write();
        t_cap_rounding();
        t_bad_line();
        t_pcix_write();
        t_reads();
        t_dac_cross();
        t_cap_zero();
        t_zero_len();
        t_stall_cfg();
        t_back_to_back();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got no completion, expected end of tests");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule